// File: doc/BRIEF.md
# Trap Entry State Update Unit

When a processor takes a trap, this unit produces every privileged state value the trap changes. A one-cycle `trap_go` strobe comes with the trap type and a target code. The target code selects one of three entries: a normal trap into the privileged level, a normal trap into the hyperprivileged level, or the error/reset state. The surrounding register file supplies the pre-trap values. These are the trap level, global level, condition codes, address space identifier, processor state word, hyperprivileged state word, window pointer, spare-window count and both program counters. One clock after the strobe, the unit presents the new values on its registered outputs and pulses `wr_stb` so the register file can load them.

The unit fills a single trap-stack slot. It packs the pre-trap global level, condition codes, ASI, state word and window pointer into one 43-bit save word. It keeps the two program counters and the hyperprivileged state, and it records the trap type. It then updates the live state as the target requires. At reset it presents the power-on values and sets the flag that stops nonprivileged code from reading the tick counter.

Top module: `trap_entry_unit`

## Requirements
- R1: While `rst_n` is low, and afterwards until the first trap, the outputs are: `tl`=6, `gl`=3, `pstate`=0x014, `hpstate`=0x024, `cwp`=0, `tt`=0x001, `tick_npt`=1, `wr_stb`=0, and `tstate`, `tpc`, `tnpc`, `htstate` all zero. `tick_npt` stays 1 at all times after reset.
- R2: In a cycle where `trap_go` is low, no output changes on the next clock except `wr_stb`, which drops to 0.
- R3: One clock after `trap_go` is sampled high, `wr_stb` is 1 for that cycle only. `tl` equals `cur_tl`+1, saturating at 6.
- R4: `tstate` packs the pre-trap values as follows: global level zero-extended into bits 42:40, condition codes in 39:32, ASI in 31:24, state word in 20:8, window pointer zero-extended into 4:0. All other bits are zero.
- R5: `tpc` and `tnpc` hold `cur_pc` and `cur_npc`. When bit 3 of `cur_pstate` (address mask) is 1, they hold only the low 32 bits, with the upper 32 bits zero.
- R6: `htstate` holds `cur_hpstate` and `tt` holds `trap_type`.
- R7: `trap_tgt` is encoded as 00 = privileged, 01 = hyperprivileged, 10 or 11 = error state. `gl` becomes min(`cur_gl`+1, L), where L is 2 for the privileged target and 3 for the other two.
- R8: For the privileged target, `pstate` is `cur_pstate` with bits 4 and 2 set, bits 3 and 1 cleared, and bit 9 set to the value of `cur_pstate` bit 8. `hpstate` equals `cur_hpstate`.
- R9: For the hyperprivileged target, `pstate` is `cur_pstate` with bit 4 set and bits 3, 1 and 9 cleared. `hpstate` is `cur_hpstate` with bit 2 set and bits 5 and 10 cleared.
- R10: For the error-state target, `pstate` keeps only bit 2 of `cur_pstate` and also has bit 4 set. `hpstate` is `cur_hpstate` with bits 5 and 2 set and bits 10 and 0 cleared.
- R11: `cwp` is adjusted according to the trap type, modulo 8. Type 0x024 adds 1. Types 0x080 to 0x0BF add `cur_cansave`+2. Types 0x0C0 to 0x0FF subtract 1. Any other type leaves `cur_cwp` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| trap_go | input | 1 | Take-trap strobe |
| trap_tgt | input | 2 | Target: 00 privileged, 01 hyperprivileged, 1x error state |
| trap_type | input | 9 | Trap type code |
| cur_tl | input | 3 | Pre-trap trap level |
| cur_gl | input | 2 | Pre-trap global level |
| cur_pstate | input | 13 | Pre-trap processor state word |
| cur_hpstate | input | 11 | Pre-trap hyperprivileged state word |
| cur_cwp | input | 3 | Pre-trap window pointer |
| cur_cansave | input | 3 | Pre-trap spare-window count |
| cur_ccr | input | 8 | Pre-trap condition codes |
| cur_asi | input | 8 | Pre-trap address space identifier |
| cur_pc | input | 64 | Trapping PC |
| cur_npc | input | 64 | Trapping next PC |
| tl | output | 3 | New trap level |
| gl | output | 2 | New global level |
| pstate | output | 13 | New processor state word |
| hpstate | output | 11 | New hyperprivileged state word |
| cwp | output | 3 | New window pointer |
| tstate | output | 43 | Packed save word |
| tpc | output | 64 | Saved PC |
| tnpc | output | 64 | Saved next PC |
| htstate | output | 11 | Saved hyperprivileged state word |
| tt | output | 9 | Saved trap type |
| tick_npt | output | 1 | Tick counter non-readable flag |
| wr_stb | output | 1 | New values valid this cycle |

## Verification
The bench runs directed traps that sit on the window-pointer edges. These include pointer 7 with type 0x024, pointer 0 with 0x0C0, the ends 0x080, 0x0BF and 0x0FF, and types just outside them (0x023, 0x100). This separates a correct wrap and correct range decoding from off-by-one decoding. The same traps send a global level of 3 into the privileged target and a trap level of 6 or 7, so clamping is distinguished from plain incrementing. State words with every bit set, and with only the address-mask bit or the bit-8 source set, show whether each target touches only its own bits. After that, a long run of random and often back-to-back traps, with biased trap types, checks every output against a behavioural model on every clock.

// File: rtl/trap_entry_pkg.sv
package trap_entry_pkg;

    localparam int PS_W   = 13;
    localparam int HPS_W  = 11;
    localparam int TT_W   = 9;
    localparam int ADDR_W = 64;
    localparam int TS_W   = 43;

    localparam int PS_IE   = 1;
    localparam int PS_PRIV = 2;
    localparam int PS_AM   = 3;
    localparam int PS_PEF  = 4;
    localparam int PS_TLE  = 8;
    localparam int PS_CLE  = 9;

    localparam int HPS_TLZ   = 0;
    localparam int HPS_HPRIV = 2;
    localparam int HPS_RED   = 5;
    localparam int HPS_IBE   = 10;

    localparam int TS_GL_LSB  = 40;
    localparam int TS_CCR_LSB = 32;
    localparam int TS_ASI_LSB = 24;
    localparam int TS_PS_LSB  = 8;
    localparam int TS_CWP_LSB = 0;

    localparam logic [PS_W-1:0]  PSTATE_POR  = 13'h014;
    localparam logic [HPS_W-1:0] HPSTATE_POR = 11'h024;
    localparam logic [TT_W-1:0]  TT_POR      = 9'h001;
    localparam logic [TT_W-1:0]  TT_WIN_INC  = 9'h024;

    typedef enum logic [1:0] {
        TGT_PRIV  = 2'b00,
        TGT_HYPER = 2'b01,
        TGT_ERR   = 2'b10,
        TGT_ERR2  = 2'b11
    } trap_tgt_e;

endpackage

// File: rtl/trap_cwp_adjust.sv
module trap_cwp_adjust
    import trap_entry_pkg::*;
#(
    parameter int NWIN = 8,
    parameter int CW   = 3
) (
    input  logic [TT_W-1:0] trap_type,
    input  logic [CW-1:0]   cwp_cur,
    input  logic [CW-1:0]   cansave,
    output logic [CW-1:0]   cwp_next
);
    localparam int SW = CW + 2;

    logic [SW-1:0] sum_d;

    always_comb begin
        sum_d = SW'(cwp_cur);
        if (trap_type == TT_WIN_INC) begin
            sum_d = SW'(cwp_cur) + SW'(1);
        end else if (trap_type[TT_W-1:6] == 3'b010) begin
            sum_d = SW'(cwp_cur) + SW'(cansave) + SW'(2);
        end else if (trap_type[TT_W-1:6] == 3'b011) begin
            sum_d = SW'(cwp_cur) + SW'(NWIN - 1);
        end
    end

    generate
        if ((NWIN & (NWIN - 1)) == 0) begin : g_pow2
            assign cwp_next = CW'(sum_d & SW'(NWIN - 1));
        end else begin : g_mod
            assign cwp_next = CW'(sum_d % SW'(NWIN));
        end
    endgenerate

endmodule

// File: rtl/trap_save_pack.sv
module trap_save_pack
    import trap_entry_pkg::*;
#(
    parameter int GLW = 2,
    parameter int CW  = 3
) (
    input  logic [GLW-1:0]    gl_cur,
    input  logic [7:0]        ccr_cur,
    input  logic [7:0]        asi_cur,
    input  logic [PS_W-1:0]   pstate_cur,
    input  logic [CW-1:0]     cwp_cur,
    input  logic [ADDR_W-1:0] pc_cur,
    input  logic [ADDR_W-1:0] npc_cur,
    output logic [TS_W-1:0]   save_word,
    output logic [ADDR_W-1:0] save_pc,
    output logic [ADDR_W-1:0] save_npc
);
    localparam logic [ADDR_W-1:0] LOW32 = {{(ADDR_W-32){1'b0}}, {32{1'b1}}};

    always_comb begin
        save_word = '0;
        save_word[TS_GL_LSB  +: GLW]  = gl_cur;
        save_word[TS_CCR_LSB +: 8]    = ccr_cur;
        save_word[TS_ASI_LSB +: 8]    = asi_cur;
        save_word[TS_PS_LSB  +: PS_W] = pstate_cur;
        save_word[TS_CWP_LSB +: CW]   = cwp_cur;

        if (pstate_cur[PS_AM]) begin
            save_pc  = pc_cur & LOW32;
            save_npc = npc_cur & LOW32;
        end else begin
            save_pc  = pc_cur;
            save_npc = npc_cur;
        end
    end

endmodule

// File: rtl/trap_level_update.sv
module trap_level_update
    import trap_entry_pkg::*;
#(
    parameter int MAX_TL  = 6,
    parameter int MAX_GL  = 3,
    parameter int MAX_PGL = 2,
    parameter int TLW     = 3,
    parameter int GLW     = 2
) (
    input  trap_tgt_e          tgt,
    input  logic [TLW-1:0]     tl_cur,
    input  logic [GLW-1:0]     gl_cur,
    input  logic [PS_W-1:0]    pstate_cur,
    input  logic [HPS_W-1:0]   hpstate_cur,
    output logic [TLW-1:0]     tl_next,
    output logic [GLW-1:0]     gl_next,
    output logic [PS_W-1:0]    pstate_next,
    output logic [HPS_W-1:0]   hpstate_next
);
    logic [GLW-1:0] gl_lim;

    always_comb begin
        tl_next = (tl_cur >= TLW'(MAX_TL)) ? TLW'(MAX_TL) : TLW'(tl_cur + 1'b1);

        gl_lim  = (tgt == TGT_PRIV) ? GLW'(MAX_PGL) : GLW'(MAX_GL);
        gl_next = (gl_cur >= gl_lim) ? gl_lim : GLW'(gl_cur + 1'b1);

        pstate_next  = pstate_cur;
        hpstate_next = hpstate_cur;
        case (tgt)
            TGT_PRIV: begin
                pstate_next[PS_PEF]  = 1'b1;
                pstate_next[PS_AM]   = 1'b0;
                pstate_next[PS_IE]   = 1'b0;
                pstate_next[PS_PRIV] = 1'b1;
                pstate_next[PS_CLE]  = pstate_cur[PS_TLE];
            end
            TGT_HYPER: begin
                pstate_next[PS_PEF]     = 1'b1;
                pstate_next[PS_AM]      = 1'b0;
                pstate_next[PS_IE]      = 1'b0;
                pstate_next[PS_CLE]     = 1'b0;
                hpstate_next[HPS_RED]   = 1'b0;
                hpstate_next[HPS_IBE]   = 1'b0;
                hpstate_next[HPS_HPRIV] = 1'b1;
            end
            default: begin
                pstate_next             = '0;
                pstate_next[PS_PRIV]    = pstate_cur[PS_PRIV];
                pstate_next[PS_PEF]     = 1'b1;
                hpstate_next[HPS_RED]   = 1'b1;
                hpstate_next[HPS_HPRIV] = 1'b1;
                hpstate_next[HPS_IBE]   = 1'b0;
                hpstate_next[HPS_TLZ]   = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/trap_entry_unit.sv
module trap_entry_unit
    import trap_entry_pkg::*;
#(
    parameter int NWIN    = 8,
    parameter int MAX_TL  = 6,
    parameter int MAX_GL  = 3,
    parameter int MAX_PGL = 2,
    localparam int TLW    = $clog2(MAX_TL + 1),
    localparam int GLW    = $clog2(MAX_GL + 1),
    localparam int CW     = $clog2(NWIN)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              trap_go,
    input  logic [1:0]        trap_tgt,
    input  logic [TT_W-1:0]   trap_type,
    input  logic [TLW-1:0]    cur_tl,
    input  logic [GLW-1:0]    cur_gl,
    input  logic [PS_W-1:0]   cur_pstate,
    input  logic [HPS_W-1:0]  cur_hpstate,
    input  logic [CW-1:0]     cur_cwp,
    input  logic [CW-1:0]     cur_cansave,
    input  logic [7:0]        cur_ccr,
    input  logic [7:0]        cur_asi,
    input  logic [ADDR_W-1:0] cur_pc,
    input  logic [ADDR_W-1:0] cur_npc,
    output logic [TLW-1:0]    tl,
    output logic [GLW-1:0]    gl,
    output logic [PS_W-1:0]   pstate,
    output logic [HPS_W-1:0]  hpstate,
    output logic [CW-1:0]     cwp,
    output logic [TS_W-1:0]   tstate,
    output logic [ADDR_W-1:0] tpc,
    output logic [ADDR_W-1:0] tnpc,
    output logic [HPS_W-1:0]  htstate,
    output logic [TT_W-1:0]   tt,
    output logic              tick_npt,
    output logic              wr_stb
);
    typedef struct packed {
        logic [TLW-1:0]    tl;
        logic [GLW-1:0]    gl;
        logic [PS_W-1:0]   pstate;
        logic [HPS_W-1:0]  hpstate;
        logic [CW-1:0]     cwp;
        logic [TS_W-1:0]   tstate;
        logic [ADDR_W-1:0] tpc;
        logic [ADDR_W-1:0] tnpc;
        logic [HPS_W-1:0]  htstate;
        logic [TT_W-1:0]   tt;
        logic              npt;
        logic              stb;
    } trap_regs_t;

    trap_regs_t regs_d, regs_q;
    trap_tgt_e  tgt;

    logic [TLW-1:0]    lvl_tl;
    logic [GLW-1:0]    lvl_gl;
    logic [PS_W-1:0]   lvl_ps;
    logic [HPS_W-1:0]  lvl_hps;
    logic [CW-1:0]     win_cwp;
    logic [TS_W-1:0]   pk_word;
    logic [ADDR_W-1:0] pk_pc;
    logic [ADDR_W-1:0] pk_npc;

    assign tgt = trap_tgt_e'(trap_tgt);

    trap_level_update #(
        .MAX_TL (MAX_TL),
        .MAX_GL (MAX_GL),
        .MAX_PGL(MAX_PGL),
        .TLW    (TLW),
        .GLW    (GLW)
    ) u_level (
        .tgt         (tgt),
        .tl_cur      (cur_tl),
        .gl_cur      (cur_gl),
        .pstate_cur  (cur_pstate),
        .hpstate_cur (cur_hpstate),
        .tl_next     (lvl_tl),
        .gl_next     (lvl_gl),
        .pstate_next (lvl_ps),
        .hpstate_next(lvl_hps)
    );

    trap_cwp_adjust #(
        .NWIN(NWIN),
        .CW  (CW)
    ) u_window (
        .trap_type(trap_type),
        .cwp_cur  (cur_cwp),
        .cansave  (cur_cansave),
        .cwp_next (win_cwp)
    );

    trap_save_pack #(
        .GLW(GLW),
        .CW (CW)
    ) u_pack (
        .gl_cur    (cur_gl),
        .ccr_cur   (cur_ccr),
        .asi_cur   (cur_asi),
        .pstate_cur(cur_pstate),
        .cwp_cur   (cur_cwp),
        .pc_cur    (cur_pc),
        .npc_cur   (cur_npc),
        .save_word (pk_word),
        .save_pc   (pk_pc),
        .save_npc  (pk_npc)
    );

    always_comb begin
        regs_d     = regs_q;
        regs_d.stb = 1'b0;
        if (trap_go) begin
            regs_d.tl      = lvl_tl;
            regs_d.gl      = lvl_gl;
            regs_d.pstate  = lvl_ps;
            regs_d.hpstate = lvl_hps;
            regs_d.cwp     = win_cwp;
            regs_d.tstate  = pk_word;
            regs_d.tpc     = pk_pc;
            regs_d.tnpc    = pk_npc;
            regs_d.htstate = cur_hpstate;
            regs_d.tt      = trap_type;
            regs_d.stb     = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q         <= '0;
            regs_q.tl      <= TLW'(MAX_TL);
            regs_q.gl      <= GLW'(MAX_GL);
            regs_q.pstate  <= PSTATE_POR;
            regs_q.hpstate <= HPSTATE_POR;
            regs_q.tt      <= TT_POR;
            regs_q.npt     <= 1'b1;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign tl       = regs_q.tl;
    assign gl       = regs_q.gl;
    assign pstate   = regs_q.pstate;
    assign hpstate  = regs_q.hpstate;
    assign cwp      = regs_q.cwp;
    assign tstate   = regs_q.tstate;
    assign tpc      = regs_q.tpc;
    assign tnpc     = regs_q.tnpc;
    assign htstate  = regs_q.htstate;
    assign tt       = regs_q.tt;
    assign tick_npt = regs_q.npt;
    assign wr_stb   = regs_q.stb;

endmodule

// File: rtl/trap_entry_chk.sv
module trap_entry_chk
    import trap_entry_pkg::*;
#(
    parameter int NWIN    = 8,
    parameter int MAX_TL  = 6,
    parameter int MAX_GL  = 3,
    parameter int MAX_PGL = 2,
    localparam int TLW    = $clog2(MAX_TL + 1),
    localparam int GLW    = $clog2(MAX_GL + 1),
    localparam int CW     = $clog2(NWIN)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              trap_go,
    input logic [1:0]        trap_tgt,
    input logic [TT_W-1:0]   trap_type,
    input logic [TLW-1:0]    cur_tl,
    input logic [PS_W-1:0]   cur_pstate,
    input logic [HPS_W-1:0]  cur_hpstate,
    input logic [TLW-1:0]    tl,
    input logic [GLW-1:0]    gl,
    input logic [PS_W-1:0]   pstate,
    input logic [HPS_W-1:0]  hpstate,
    input logic [CW-1:0]     cwp,
    input logic [TS_W-1:0]   tstate,
    input logic [ADDR_W-1:0] tpc,
    input logic [ADDR_W-1:0] tnpc,
    input logic [HPS_W-1:0]  htstate,
    input logic [TT_W-1:0]   tt,
    input logic              wr_stb
);

    // R2: idle cycles leave the state alone
    p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !trap_go |=> ($stable(tl) && $stable(gl) && $stable(pstate) && $stable(cwp)
                      && $stable(tstate) && !wr_stb));

    // R3: trap level steps by one below the ceiling, strobe follows
    p_tl_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_go && (cur_tl < TLW'(MAX_TL))) |=> (tl == TLW'($past(cur_tl) + 1'b1) && wr_stb));

    // R5: address mask drops the upper halves of both saved PCs
    p_pc_mask_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_go && cur_pstate[PS_AM]) |=> (tpc[ADDR_W-1:32] == '0 && tnpc[ADDR_W-1:32] == '0));

    // R6: trap type and hyperprivileged state are captured
    p_capture_r6: assert property (@(posedge clk) disable iff (!rst_n)
        trap_go |=> (tt == $past(trap_type) && htstate == $past(cur_hpstate)));

    // R7: a privileged target never leaves the global level above its cap
    p_gl_cap_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_go && trap_tgt == 2'b00) |=> (gl <= GLW'(MAX_PGL)));

    // R10: error-state entry forces the hyperprivileged control bits
    p_err_hps_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_go && trap_tgt[1]) |=> (hpstate[HPS_RED] && hpstate[HPS_HPRIV]
                                     && !hpstate[HPS_IBE] && !hpstate[HPS_TLZ]
                                     && pstate[PS_PEF]));

endmodule

bind trap_entry_unit trap_entry_chk #(
    .NWIN   (NWIN),
    .MAX_TL (MAX_TL),
    .MAX_GL (MAX_GL),
    .MAX_PGL(MAX_PGL)
) u_chk (.*);

// File: tb/tb_trap_entry_unit.sv
`timescale 1ns/1ps
module tb_trap_entry_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        go = 1'b0;
    logic [1:0]  tgt = 2'b00;
    logic [8:0]  ttype = '0;
    logic [2:0]  c_tl = '0;
    logic [1:0]  c_gl = '0;
    logic [12:0] c_ps = '0;
    logic [10:0] c_hps = '0;
    logic [2:0]  c_cwp = '0;
    logic [2:0]  c_cs = '0;
    logic [7:0]  c_ccr = '0;
    logic [7:0]  c_asi = '0;
    logic [63:0] c_pc = '0;
    logic [63:0] c_npc = '0;

    logic [2:0]  o_tl;
    logic [1:0]  o_gl;
    logic [12:0] o_ps;
    logic [10:0] o_hps;
    logic [2:0]  o_cwp;
    logic [42:0] o_ts;
    logic [63:0] o_tpc, o_tnpc;
    logic [10:0] o_hts;
    logic [8:0]  o_tt;
    logic        o_npt, o_stb;

    always #4 clk = ~clk;

    trap_entry_unit dut (
        .clk(clk), .rst_n(rst_n), .trap_go(go), .trap_tgt(tgt), .trap_type(ttype),
        .cur_tl(c_tl), .cur_gl(c_gl), .cur_pstate(c_ps), .cur_hpstate(c_hps),
        .cur_cwp(c_cwp), .cur_cansave(c_cs), .cur_ccr(c_ccr), .cur_asi(c_asi),
        .cur_pc(c_pc), .cur_npc(c_npc),
        .tl(o_tl), .gl(o_gl), .pstate(o_ps), .hpstate(o_hps), .cwp(o_cwp),
        .tstate(o_ts), .tpc(o_tpc), .tnpc(o_tnpc), .htstate(o_hts), .tt(o_tt),
        .tick_npt(o_npt), .wr_stb(o_stb)
    );

    int checks = 0;
    int fails  = 0;
    bit started = 0;
    bit done = 0;
    int kind = 0;
    int e_mode = 0;

    longint unsigned e_tl, e_gl, e_ps, e_hps, e_cwp, e_ts, e_tpc, e_tnpc, e_hts, e_tt, e_npt, e_stb;

    task automatic cmp(input string tag, input longint unsigned act, input longint unsigned exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // behavioural reference model, updated at each rising edge
    always @(posedge clk) begin
        if (!rst_n) begin
            e_tl = 6; e_gl = 3; e_ps = 'h014; e_hps = 'h024; e_cwp = 0;
            e_ts = 0; e_tpc = 0; e_tnpc = 0; e_hts = 0; e_tt = 1; e_npt = 1; e_stb = 0;
            kind = 0;
        end else if (go) begin
            longint unsigned ps, hps, lim, g, t, w;
            ps = c_ps; hps = c_hps;
            e_ts = (longint'(c_gl) << 40) | (longint'(c_ccr) << 32) | (longint'(c_asi) << 24)
                 | (longint'(c_ps) << 8) | longint'(c_cwp);
            if (c_ps[3]) begin
                e_tpc = c_pc & 64'h0000_0000_FFFF_FFFF;
                e_tnpc = c_npc & 64'h0000_0000_FFFF_FFFF;
            end else begin
                e_tpc = c_pc; e_tnpc = c_npc;
            end
            e_hts = c_hps;
            e_tt = ttype;
            t = c_tl + 1; e_tl = (t > 6) ? 6 : t;
            lim = (tgt == 2'b00) ? 2 : 3;
            g = c_gl + 1; e_gl = (g > lim) ? lim : g;
            if (tgt == 2'b00) begin
                ps = (ps | 'h14) & ~longint'('h00A);
                ps = (ps & ~longint'('h200)) | (c_ps[8] ? 'h200 : 0);
            end else if (tgt == 2'b01) begin
                ps = (ps | 'h10) & ~longint'('h20A);
                hps = (hps & ~longint'('h420)) | 'h4;
            end else begin
                ps = (ps & 'h4) | 'h10;
                hps = (hps | 'h24) & ~longint'('h401);
            end
            e_ps = ps; e_hps = hps;
            w = c_cwp;
            if (ttype == 9'h024) w = (w + 1) % 8;
            else if (ttype >= 9'h080 && ttype <= 9'h0BF) w = (w + c_cs + 2) % 8;
            else if (ttype >= 9'h0C0 && ttype <= 9'h0FF) w = (w + 7) % 8;
            e_cwp = w;
            e_stb = 1;
            e_mode = tgt;
            kind = 2;
        end else begin
            e_stb = 0;
            kind = 1;
        end
        started = 1;
    end

    // comparison away from the active edge
    always @(negedge clk) begin
        if (started && !done) begin
            string rp;
            if (kind == 0) begin
                cmp("R1 tl", o_tl, e_tl);       cmp("R1 gl", o_gl, e_gl);
                cmp("R1 pstate", o_ps, e_ps);   cmp("R1 hpstate", o_hps, e_hps);
                cmp("R1 cwp", o_cwp, e_cwp);    cmp("R1 tstate", o_ts, e_ts);
                cmp("R1 tpc", o_tpc, e_tpc);    cmp("R1 tnpc", o_tnpc, e_tnpc);
                cmp("R1 htstate", o_hts, e_hts); cmp("R1 tt", o_tt, e_tt);
                cmp("R1 wr_stb", o_stb, e_stb);
            end else if (kind == 1) begin
                cmp("R2 tl", o_tl, e_tl);       cmp("R2 gl", o_gl, e_gl);
                cmp("R2 pstate", o_ps, e_ps);   cmp("R2 hpstate", o_hps, e_hps);
                cmp("R2 cwp", o_cwp, e_cwp);    cmp("R2 tstate", o_ts, e_ts);
                cmp("R2 tpc", o_tpc, e_tpc);    cmp("R2 tnpc", o_tnpc, e_tnpc);
                cmp("R2 htstate", o_hts, e_hts); cmp("R2 tt", o_tt, e_tt);
                cmp("R2 wr_stb", o_stb, e_stb);
            end else begin
                rp = (e_mode == 0) ? "R8" : (e_mode == 1) ? "R9" : "R10";
                cmp("R3 tl", o_tl, e_tl);       cmp("R3 wr_stb", o_stb, e_stb);
                cmp("R7 gl", o_gl, e_gl);
                cmp({rp, " pstate"}, o_ps, e_ps);
                cmp({rp, " hpstate"}, o_hps, e_hps);
                cmp("R11 cwp", o_cwp, e_cwp);   cmp("R4 tstate", o_ts, e_ts);
                cmp("R5 tpc", o_tpc, e_tpc);    cmp("R5 tnpc", o_tnpc, e_tnpc);
                cmp("R6 htstate", o_hts, e_hts); cmp("R6 tt", o_tt, e_tt);
            end
            cmp("R1 tick_npt", o_npt, e_npt);
        end
    end

    task automatic trap(input logic [1:0] m, input logic [8:0] t, input logic [2:0] tlv,
                        input logic [1:0] glv, input logic [2:0] cw, input logic [2:0] cs,
                        input logic [12:0] ps);
        @(negedge clk);
        go = 1'b1; tgt = m; ttype = t; c_tl = tlv; c_gl = glv; c_cwp = cw; c_cs = cs;
        c_ps = ps; c_hps = 11'h5A5; c_ccr = 8'hC3; c_asi = 8'h3C;
        c_pc = 64'hDEAD_BEEF_0123_4560; c_npc = 64'hDEAD_BEEF_0123_4564;
        @(negedge clk);
        go = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);                       // R1 after release, R2 idle
        trap(2'b00, 9'h024, 3'd0, 2'd0, 3'd7, 3'd0, 13'h0100); // R11 wrap up, R8 bit9 from bit8
        trap(2'b01, 9'h0C0, 3'd5, 2'd3, 3'd0, 3'd3, 13'h1FFF); // R11 wrap down, R9
        trap(2'b00, 9'h080, 3'd6, 2'd3, 3'd7, 3'd7, 13'h0008); // R3 sat, R7 gl 3->2, R5 mask
        trap(2'b10, 9'h0BF, 3'd7, 2'd1, 3'd2, 3'd5, 13'h1FFF); // R10, R11 range top
        trap(2'b11, 9'h100, 3'd2, 2'd3, 3'd4, 3'd1, 13'h1FFB); // R10 alt code, R11 no change
        trap(2'b01, 9'h0FF, 3'd1, 2'd1, 3'd3, 3'd2, 13'h0000); // R7 gl 1->2, R11 range end
        trap(2'b00, 9'h023, 3'd3, 2'd1, 3'd5, 3'd6, 13'h0ABC); // R11 below 0x024
        trap(2'b00, 9'h07F, 3'd4, 2'd2, 3'd1, 3'd6, 13'h1EF7); // R7 gl at cap
        for (int i = 0; i < 600; i++) begin
            @(negedge clk);
            go    = ($urandom % 4) != 0;
            tgt   = 2'($urandom);
            case ($urandom % 4)
                0: ttype = 9'h024;
                1: ttype = 9'h080 + 9'($urandom % 64);
                2: ttype = 9'h0C0 + 9'($urandom % 64);
                default: ttype = 9'($urandom);
            endcase
            c_tl  = 3'($urandom);  c_gl = 2'($urandom);
            c_ps  = 13'($urandom); c_hps = 11'($urandom);
            c_cwp = 3'($urandom);  c_cs = 3'($urandom);
            c_ccr = 8'($urandom);  c_asi = 8'($urandom);
            c_pc  = {32'($urandom), 32'($urandom)};
            c_npc = {32'($urandom), 32'($urandom)};
        end
        @(negedge clk);
        go = 1'b0;
        repeat (3) @(negedge clk);
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired: actual=running expected=finished");
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule